// File: doc/BRIEF.md
# Snapshot Switch Monitor with Serial Readout

This block watches a bank of parallel switch inputs and lets a host read them over a four-wire serial link. The link has an active-low select, a serial clock, a serial data input and a serial data output. Each time the host pulls select low, the block freezes a copy of the inputs. The first serial clock rise after that moves the copy into a shift register. The copy then leaves the block most significant bit first, one bit per rising clock edge.

While select is low, the block samples the serial data input on every falling clock edge. Those bits follow the block's own bits on the serial output. Several monitors can therefore be chained, with the output of one feeding the input of the next.

A second function watches the inputs between reads. Whenever the synchronised inputs differ from the frozen copy, the block pulls its open-drain interrupt line low. The interrupt lets go when select falls again, because that takes a new copy. It also lets go when the inputs return to the copied values. An enable input can keep the interrupt line released.

The block runs on a fast system clock and oversamples every pin. The system clock must be at least eight times the serial clock rate.

Top module: `snap_spi_monitor`

## Requirements
- R1: The falling edge of select stores the synchronised inputs in the status register. Changes to the inputs after that edge do not alter the word read out in the same transfer.
- R2: With select low, the first serial clock rise loads the shift register from the status register, and the MSB appears on sdo_o. Every new select restarts at the MSB of the new copy, even when the previous transfer stopped early.
- R3: Each later rising clock edge moves the next lower bit onto sdo_o. sdo_o changes on no other event.
- R4: The serial data input is sampled on falling clock edges only while select is low. After the NUM_INPUTS own bits, the next bits on sdo_o are the serial input bits, in the order they arrived. Clock and data activity while select is high has no effect.
- R5: sdo_oe_o is 0 while select is high and 1 while select is low, once the two-flop synchroniser delay has passed.
- R6: irq_oe_o is 1 (line pulled low) when the enable is high and the synchronised inputs differ from the status register.
- R7: The interrupt is released on the cycle after a select fall is detected.
- R8: The interrupt is released when the inputs return to the stored copy, with no serial access.
- R9: While irq_en_i is low, irq_oe_o stays 0. Raising the enable while a mismatch exists asserts it.
- R10: After reset the status and shift registers are zero, sdo_oe_o is 0, sdo_o is 0 and irq_oe_o is 0.
- R11: An input change that reaches the block in the same cycle as a select fall goes into the copy and raises no interrupt, not even for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_i | input | NUM_INPUTS | Switch inputs being monitored |
| cs_ni | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in from an upstream monitor |
| irq_en_i | input | 1 | Interrupt enable, active high |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for sdo_o; 0 means high-impedance |
| irq_oe_o | output | 1 | Open-drain interrupt: 1 pulls the line low, 0 releases it |

## Verification
Two functions can fall in the same system cycle: taking the snapshot on a select fall, and detecting an input mismatch. The inputs and select pass through the same synchroniser depth. The bench therefore changes the switch pattern and drops select on the same clock edge, so the new inputs and the select edge arrive at the comparator together. It then watches irq_oe_o on every cycle and requires it to stay released. It also requires the following readout to return the new pattern, which shows the snapshot kept the change rather than the old value.

// File: rtl/snapmon_pkg.sv
package snapmon_pkg;
  typedef struct packed {
    logic cs_fall;
    logic sck_rise;
    logic sck_fall;
  } spi_evt_t;
endpackage

// File: rtl/snapmon_sync.sv
module snapmon_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/snapmon_edges.sv
module snapmon_edges
  import snapmon_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cs_s_i,
  input  logic     sck_s_i,
  output spi_evt_t evt_o
);
  logic cs_q, sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s_i;
      sck_q <= sck_s_i;
    end
  end

  // serial clock edges only count while selected
  assign evt_o.cs_fall  = cs_q & ~cs_s_i;
  assign evt_o.sck_rise = ~sck_q & sck_s_i & ~cs_s_i;
  assign evt_o.sck_fall = sck_q & ~sck_s_i & ~cs_s_i;
endmodule

// File: rtl/snapmon_shifter.sv
module snapmon_shifter
  import snapmon_pkg::*;
#(
  parameter int NUM_INPUTS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  spi_evt_t              evt_i,
  input  logic [NUM_INPUTS-1:0] sw_s_i,
  input  logic                  sdi_s_i,
  output logic [NUM_INPUTS-1:0] status_o,
  output logic                  sdo_o
);
  logic [NUM_INPUTS-1:0] status_q, shreg_q;
  logic                  loaded_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else if (evt_i.cs_fall) status_q <= sw_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               loaded_q <= 1'b0;
    else if (evt_i.cs_fall)    loaded_q <= 1'b0;
    else if (evt_i.sck_rise)   loaded_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rx_q <= 1'b0;
    else if (evt_i.sck_fall) rx_q <= sdi_s_i;
  end

  // first rise after select loads, later rises shift in the held input bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shreg_q <= '0;
    else if (evt_i.sck_rise) begin
      if (!loaded_q) shreg_q <= status_q;
      else           shreg_q <= {shreg_q[NUM_INPUTS-2:0], rx_q};
    end
  end

  assign status_o = status_q;
  assign sdo_o    = shreg_q[NUM_INPUTS-1];
endmodule

// File: rtl/snapmon_irq.sv
module snapmon_irq #(
  parameter int NUM_INPUTS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_s_i,
  input  logic                  cs_fall_i,
  input  logic [NUM_INPUTS-1:0] sw_s_i,
  input  logic [NUM_INPUTS-1:0] status_i,
  output logic                  irq_oe_o
);
  logic irq_q;

  // a select fall reloads the status with sw_s_i, so no mismatch that cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= en_s_i & ~cs_fall_i & (sw_s_i != status_i);
  end

  assign irq_oe_o = irq_q;
endmodule

// File: rtl/snap_spi_monitor.sv
module snap_spi_monitor
  import snapmon_pkg::*;
#(
  parameter int NUM_INPUTS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_INPUTS-1:0] sw_i,
  input  logic                  cs_ni,
  input  logic                  sck_i,
  input  logic                  sdi_i,
  input  logic                  irq_en_i,
  output logic                  sdo_o,
  output logic                  sdo_oe_o,
  output logic                  irq_oe_o
);
  localparam int SYNC_W = NUM_INPUTS + 4;
  localparam logic [SYNC_W-1:0] SYNC_RST = {4'b0001, {NUM_INPUTS{1'b0}}};

  logic [SYNC_W-1:0]     raw, synced;
  logic [NUM_INPUTS-1:0] sw_s, status_q;
  logic                  cs_s, sck_s, sdi_s, en_s;
  spi_evt_t              evt;

  assign raw = {irq_en_i, sdi_i, sck_i, cs_ni, sw_i};

  snapmon_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign {en_s, sdi_s, sck_s, cs_s, sw_s} = synced;

  snapmon_edges i_edges (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_s_i (cs_s),
    .sck_s_i(sck_s),
    .evt_o  (evt)
  );

  snapmon_shifter #(.NUM_INPUTS(NUM_INPUTS)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .sw_s_i  (sw_s),
    .sdi_s_i (sdi_s),
    .status_o(status_q),
    .sdo_o   (sdo_o)
  );

  snapmon_irq #(.NUM_INPUTS(NUM_INPUTS)) i_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_s_i   (en_s),
    .cs_fall_i(evt.cs_fall),
    .sw_s_i   (sw_s),
    .status_i (status_q),
    .irq_oe_o (irq_oe_o)
  );

  assign sdo_oe_o = ~cs_s;
endmodule

// File: rtl/snapmon_checker.sv
module snapmon_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic sdo_i,
  input logic sdo_oe_i,
  input logic irq_oe_i,
  input logic en_s_i,
  input logic cs_fall_i,
  input logic sck_rise_i,
  input logic loaded_i,
  input logic status_msb_i,
  input logic shreg_next_i
);
  logic [1:0] up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           up_q <= '0;
    else if (up_q != 2'd3) up_q <= up_q + 2'd1;
  end

  AST_SDO_OE_TRACKS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q >= 2'd2) |-> (sdo_oe_i == !$past(cs_ni, 2))); // R5

  AST_LOAD_PUTS_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_rise_i && !loaded_i) |=> (sdo_i == $past(status_msb_i))); // R2

  AST_SHIFT_NEXT_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_rise_i && loaded_i) |=> (sdo_i == $past(shreg_next_i))); // R3

  AST_SDO_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_rise_i |=> $stable(sdo_i)); // R3

  AST_IRQ_CLEARS_ON_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> !irq_oe_i); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s_i |=> !irq_oe_i); // R9
endmodule

bind snap_spi_monitor snapmon_checker i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .sdo_i       (sdo_o),
  .sdo_oe_i    (sdo_oe_o),
  .irq_oe_i    (irq_oe_o),
  .en_s_i      (en_s),
  .cs_fall_i   (evt.cs_fall),
  .sck_rise_i  (evt.sck_rise),
  .loaded_i    (i_shift.loaded_q),
  .status_msb_i(status_q[NUM_INPUTS-1]),
  .shreg_next_i(i_shift.shreg_q[NUM_INPUTS-2])
);

// File: tb/test_snap_spi_monitor.sv
module test_snap_spi_monitor;
  localparam int N  = 16;
  localparam int NV = 5;
  localparam logic [N-1:0]  V_SW [NV] = '{16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF, 16'h0000};
  localparam logic          V_EN [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [31:0]   V_UP [NV] = '{32'h1234_5678, 32'hFFFF_0000, 32'h0F0F_F0F0,
                                          32'h0000_0000, 32'hDEAD_BEEF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] sw = '0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, en = 1'b1;
  logic sdo, sdo_oe, irq_oe;
  int total = 0, bad = 0, cyc = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  snap_spi_monitor #(.NUM_INPUTS(N)) i_snap_spi_monitor (
    .clk_i(clk), .rst_ni(rst_n), .sw_i(sw), .cs_ni(cs_n), .sck_i(sck),
    .sdi_i(sdi), .irq_en_i(en), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .irq_oe_o(irq_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_low();
    @(negedge clk) cs_n = 1'b0;
    wait_clk(8);
  endtask

  task automatic sel_high();
    @(negedge clk) cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic clk_bits(input int n, input logic [31:0] up,
                          output logic [31:0] rd, output logic oe_ok);
    rd = '0;
    oe_ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sck = 1'b1;
      sdi = up[31-i];
      wait_clk(6);
      rd = {rd[30:0], sdo};
      if (!sdo_oe) oe_ok = 1'b0;
      wait_clk(2);
      sck = 1'b0;
      wait_clk(8);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (!done && cyc > 100000) begin
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp<100000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [N-1:0] snap;
    logic [31:0] rd, rd2;
    logic ok;
    int hits;

    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R10 sdo_oe", {31'b0, sdo_oe}, 32'd0);
    chk("R10 irq",    {31'b0, irq_oe}, 32'd0);
    chk("R10 sdo",    {31'b0, sdo},    32'd0);
    snap = '0;

    // table: pattern, enable, upstream word
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      sw = V_SW[v];
      en = V_EN[v];
      wait_clk(10);
      chk("R6/R9 irq before read", {31'b0, irq_oe}, {31'b0, (V_EN[v] && (V_SW[v] != snap))});
      sel_low();
      chk("R7 irq after select", {31'b0, irq_oe}, 32'd0);
      chk("R5 oe while selected", {31'b0, sdo_oe}, 32'd1);
      clk_bits(32, V_UP[v], rd, ok);
      chk("R2/R3/R4 chained read", rd, {V_SW[v], V_UP[v][31:16]});
      chk("R5 oe during shift", {31'b0, ok}, 32'd1);
      sel_high();
      chk("R5 oe idle", {31'b0, sdo_oe}, 32'd0);
      snap = V_SW[v];
    end
    en = 1'b1;

    // R1: mid-transfer change does not alter the word
    @(negedge clk) sw = 16'h1111;
    sel_low(); clk_bits(16, 32'h0, rd, ok); sel_high();
    @(negedge clk) sw = 16'h2222;
    sel_low();
    clk_bits(4, 32'h0, rd, ok);
    @(negedge clk) sw = 16'h3333;
    wait_clk(10);
    chk("R6 irq while selected", {31'b0, irq_oe}, 32'd1);
    clk_bits(12, 32'h0, rd2, ok);
    chk("R1 frozen snapshot", {16'h0, rd[3:0], rd2[11:0]}, 32'h2222);
    sel_high();
    chk("R6 irq after read", {31'b0, irq_oe}, 32'd1);

    // R8: inputs return to the copy
    @(negedge clk) sw = 16'h2222;
    wait_clk(10);
    chk("R8 self release", {31'b0, irq_oe}, 32'd0);

    // R2: aborted transfer, next one restarts at MSB
    sel_low(); clk_bits(5, 32'h0, rd, ok); sel_high();
    chk("R2 partial top bits", rd, 32'h4);
    @(negedge clk) sw = 16'h4321;
    sel_low(); clk_bits(16, 32'h0, rd, ok); sel_high();
    chk("R2 restart at MSB", rd, 32'h4321);

    // R9: enable gating
    @(negedge clk) begin en = 1'b0; sw = 16'h0F0F; end
    wait_clk(10);
    chk("R9 masked", {31'b0, irq_oe}, 32'd0);
    @(negedge clk) en = 1'b1;
    wait_clk(10);
    chk("R9 unmasked", {31'b0, irq_oe}, 32'd1);

    // R11: input change coincides with select fall
    sel_low(); clk_bits(16, 32'h0, rd, ok); sel_high();
    @(negedge clk) begin sw = 16'hABCD; cs_n = 1'b0; end
    hits = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (irq_oe) hits++;
    end
    chk("R11 no irq pulse", hits, 32'd0);
    clk_bits(16, 32'h0, rd, ok);
    chk("R11 new value captured", rd, 32'hABCD);
    sel_high();

    // R4: clock and data activity while deselected is ignored
    ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) begin sck = 1'b1; sdi = 1'b1; end
      wait_clk(8);
      if (sdo_oe) ok = 1'b0;
      @(negedge clk) begin sck = 1'b0; sdi = 1'b0; end
      wait_clk(8);
    end
    chk("R5 oe stays off", {31'b0, ok}, 32'd1);
    sel_low(); clk_bits(32, 32'h0000_0000, rd, ok); sel_high();
    chk("R4 deselected activity ignored", rd, 32'hABCD_0000);

    done = 1'b1;
    finish_run();
  end
endmodule